// File: doc/BRIEF.md
# UART Auto-Baud Handshake Detector

This block finds the bit rate of a serial host before a boot loader takes over the link. After a start strobe it watches the receive line while the host keeps sending the byte 0x00. A 0x00 frame holds the line low for nine bit times: the start bit and eight zero data bits. The block times that low run in system clocks, divides it by nine with rounding, and keeps the result as the bit-period divisor that sets both directions of the link.

Several low runs are measured in a row. The divisor is accepted only if every run gives a value within one count of the first one, and only if that value lies inside the window configured for the supported host rates (4800, 9600 and 19200 bps at the current clock). Once it is accepted, the block sends one 0x00 byte back as the end-of-adjustment sign. It then expects a single 0x55 byte, framed as 8 data bits, one stop bit and no parity. A correct 0x55 raises `locked`. Any failure raises `error`. Either flag stays set until reset.

Top module: `autobaud_sync`

## Requirements
- R1: After reset, `txd` is high, `locked` and `error` are low and `divisor` is 0. Activity on `rxd` before a `start` pulse has no effect on any output.
- R2: A low run is the number of clocks the synchronized receive level stays low, from its falling edge to its next rising edge. The divisor candidate is that count divided by 9, rounded to the nearest integer: a remainder of 4 or less rounds down and a remainder of 5 or more rounds up.
- R3: `NUM_MEAS` consecutive low runs are measured. Each candidate must differ from the first candidate by at most 1, and `divisor` then reports the first candidate. A larger difference raises `error`.
- R4: A candidate below `MIN_DIV` or above `MAX_DIV` raises `error` and no acknowledgement is sent. A candidate equal to either bound is accepted.
- R5: After acceptance, `txd` sends exactly one 0x00 frame: a low start bit, eight low data bits and a high stop bit, each lasting exactly `divisor` clocks. At all other times `txd` idles high.
- R6: After the acknowledgement, a start edge on `rxd` is checked at half a bit period. Each data bit is then sampled one bit period later than the previous sample, least significant bit first. A received 0x55 with a high stop bit raises `locked`.
- R7: A received byte other than 0x55, or a stop bit sampled low, raises `error`.
- R8: If no start edge arrives within `TIMEOUT_CYC` clocks after the acknowledgement ends, `error` is raised.
- R9: `locked` and `error` are never high together. Both stay set until reset. After `locked` rises, `divisor` holds its value and later `rxd` traffic does not change any output.
- R10: A low run that reaches the counter's full scale (`2**CNT_W - 1` clocks) raises `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts rate detection |
| rxd | input | 1 | Serial receive line from the host (asynchronous) |
| txd | output | 1 | Serial transmit line to the host |
| divisor | output | DIV_W | Clocks per bit once accepted; 0 before acceptance |
| locked | output | 1 | Handshake completed; held until reset |
| error | output | 1 | Handshake failed; held until reset |

## Verification
The bench builds the block with `CNT_W=12`, `DIV_W=8`, `MIN_DIV=10`, `MAX_DIV=40`, `NUM_MEAS=2` and `TIMEOUT_CYC=3000`. With these values a nominal bit is twenty clocks and both divisor bounds sit close to it, so rounding on either side of a half count and both edges of the range window can be driven directly. The small counter width makes saturation on a stuck-low line reachable in about four thousand clocks. The short timeout lets the missing-confirmation path be covered in a few thousand cycles.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

  localparam logic [7:0] ACK_BYTE     = 8'h00;
  localparam logic [7:0] CONFIRM_BYTE = 8'h55;

  // Strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic measTake;   // latch or compare the current low-run candidate
    logic timerHalf;  // load bit timer with half a bit period
    logic timerFull;  // load bit timer with a full bit period
    logic rxShift;    // shift the sampled receive level into the byte
    logic txLoad;     // load the acknowledgement frame
    logic txShift;    // advance the transmit frame by one bit
    logic toRun;      // advance the confirmation timeout counter
    logic toClear;    // clear the confirmation timeout counter
  } abCtrl_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEEK,
    ST_LOW,
    ST_TX_INIT,
    ST_TX_BIT,
    ST_RX_IDLE,
    ST_RX_START,
    ST_RX_DATA,
    ST_RX_STOP,
    ST_LOCK,
    ST_FAIL
  } abState_t;

endpackage

// File: rtl/autobaud_datapath.sv
module autobaud_datapath
  import autobaud_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int DIV_W       = 16,
  parameter int MIN_DIV     = 2000,
  parameter int MAX_DIV     = 12000,
  parameter int TIMEOUT_CYC = 5000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  abCtrl_t          ctrl,
  input  logic             measFirst,
  output logic             fallEdge,
  output logic             riseEdge,
  output logic             rxLevel,
  output logic             lowSat,
  output logic             measBad,
  output logic             timerDone,
  output logic             timeoutHit,
  output logic [7:0]       rxByte,
  output logic [DIV_W-1:0] divisor,
  output logic             txd
);

  localparam int SUM_W = CNT_W + 1;
  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};

  // ---------------- receive synchronizer and edge detect ----------------
  logic [1:0] syncQ;
  logic       rxPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ  <= 2'b11;
      rxPrev <= 1'b1;
    end else begin
      syncQ  <= {syncQ[0], rxd};
      rxPrev <= syncQ[1];
    end
  end

  assign rxLevel  = syncQ[1];
  assign fallEdge = rxPrev & ~rxLevel;
  assign riseEdge = ~rxPrev & rxLevel;

  // ---------------- low-run counter ----------------
  logic [CNT_W-1:0] lowCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowCnt <= '0;
    end else if (fallEdge) begin
      lowCnt <= CNT_W'(1);
    end else if (!rxLevel && lowCnt != CNT_FULL) begin
      lowCnt <= lowCnt + CNT_W'(1);
    end
  end

  assign lowSat = (lowCnt == CNT_FULL);

  // ---------------- divide by nine with rounding ----------------
  logic [SUM_W-1:0] roundSum;
  logic [SUM_W-1:0] quot;
  logic [31:0]      q32;
  logic [31:0]      d32;
  logic [31:0]      gap;
  logic             outOfRange;

  assign roundSum   = {1'b0, lowCnt} + SUM_W'(4);
  assign quot       = roundSum / SUM_W'(9);
  assign q32        = 32'(quot);
  assign d32        = 32'(divisor);
  assign gap        = (q32 > d32) ? (q32 - d32) : (d32 - q32);
  assign outOfRange = (q32 < 32'(MIN_DIV)) || (q32 > 32'(MAX_DIV));
  assign measBad    = outOfRange || (!measFirst && gap > 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divisor <= '0;
    end else if (ctrl.measTake && measFirst) begin
      divisor <= DIV_W'(quot);
    end
  end

  // ---------------- shared bit timer ----------------
  logic [DIV_W-1:0] bitTimer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitTimer <= '0;
    end else if (ctrl.timerFull) begin
      bitTimer <= divisor - DIV_W'(1);
    end else if (ctrl.timerHalf) begin
      bitTimer <= (divisor >> 1) - DIV_W'(1);
    end else if (bitTimer != '0) begin
      bitTimer <= bitTimer - DIV_W'(1);
    end
  end

  assign timerDone = (bitTimer == '0);

  // ---------------- receive shifter ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxByte <= '0;
    end else if (ctrl.rxShift) begin
      rxByte <= {rxLevel, rxByte[7:1]};
    end
  end

  // ---------------- transmit frame shifter ----------------
  logic [9:0] txFrame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txFrame <= '1;
    end else if (ctrl.txLoad) begin
      txFrame <= {1'b1, ACK_BYTE, 1'b0};
    end else if (ctrl.txShift) begin
      txFrame <= {1'b1, txFrame[9:1]};
    end
  end

  assign txd = txFrame[0];

  // ---------------- confirmation timeout ----------------
  logic [TO_W-1:0] toCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toCnt <= '0;
    end else if (ctrl.toClear) begin
      toCnt <= '0;
    end else if (ctrl.toRun && !timeoutHit) begin
      toCnt <= toCnt + TO_W'(1);
    end
  end

  assign timeoutHit = (toCnt == TO_W'(TIMEOUT_CYC));

endmodule

// File: rtl/autobaud_control.sv
module autobaud_control
  import autobaud_pkg::*;
#(
  parameter int NUM_MEAS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       fallEdge,
  input  logic       riseEdge,
  input  logic       rxLevel,
  input  logic       lowSat,
  input  logic       measBad,
  input  logic       timerDone,
  input  logic       timeoutHit,
  input  logic [7:0] rxByte,
  output abCtrl_t    ctrl,
  output logic       measFirst,
  output logic       locked,
  output logic       error
);

  localparam int MW = (NUM_MEAS > 1) ? $clog2(NUM_MEAS) : 1;
  localparam logic [MW-1:0] LAST_MEAS = MW'(NUM_MEAS - 1);

  abState_t      state, nxt;
  logic [MW-1:0] measIdx, measNxt;
  logic [3:0]    bitCnt, bitNxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      measIdx <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= nxt;
      measIdx <= measNxt;
      bitCnt  <= bitNxt;
    end
  end

  always_comb begin
    nxt     = state;
    measNxt = measIdx;
    bitNxt  = bitCnt;
    ctrl    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) nxt = ST_SEEK;
      end
      ST_SEEK: begin
        if (fallEdge) nxt = ST_LOW;
      end
      ST_LOW: begin
        if (lowSat) begin
          nxt = ST_FAIL;
        end else if (riseEdge) begin
          if (measBad) begin
            nxt = ST_FAIL;
          end else begin
            ctrl.measTake = 1'b1;
            if (measIdx == LAST_MEAS) begin
              nxt = ST_TX_INIT;
            end else begin
              measNxt = measIdx + MW'(1);
              nxt     = ST_SEEK;
            end
          end
        end
      end
      ST_TX_INIT: begin
        ctrl.txLoad    = 1'b1;
        ctrl.timerFull = 1'b1;
        ctrl.toClear   = 1'b1;
        bitNxt         = '0;
        nxt            = ST_TX_BIT;
      end
      ST_TX_BIT: begin
        if (timerDone) begin
          if (bitCnt == 4'd9) begin
            nxt = ST_RX_IDLE;
          end else begin
            ctrl.txShift   = 1'b1;
            ctrl.timerFull = 1'b1;
            bitNxt         = bitCnt + 4'd1;
          end
        end
      end
      ST_RX_IDLE: begin
        ctrl.toRun = 1'b1;
        if (timeoutHit) begin
          nxt = ST_FAIL;
        end else if (fallEdge) begin
          ctrl.timerHalf = 1'b1;
          nxt            = ST_RX_START;
        end
      end
      ST_RX_START: begin
        if (timerDone) begin
          if (!rxLevel) begin
            ctrl.timerFull = 1'b1;
            bitNxt         = '0;
            nxt            = ST_RX_DATA;
          end else begin
            nxt = ST_RX_IDLE;
          end
        end
      end
      ST_RX_DATA: begin
        if (timerDone) begin
          ctrl.rxShift   = 1'b1;
          ctrl.timerFull = 1'b1;
          if (bitCnt == 4'd7) nxt = ST_RX_STOP;
          else bitNxt = bitCnt + 4'd1;
        end
      end
      ST_RX_STOP: begin
        if (timerDone) begin
          nxt = (rxLevel && rxByte == CONFIRM_BYTE) ? ST_LOCK : ST_FAIL;
        end
      end
      default: ;
    endcase
  end

  assign measFirst = (measIdx == '0);
  assign locked    = (state == ST_LOCK);
  assign error     = (state == ST_FAIL);

endmodule

// File: rtl/autobaud_sync.sv
module autobaud_sync
  import autobaud_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int DIV_W       = 16,
  parameter int MIN_DIV     = 2000,
  parameter int MAX_DIV     = 12000,
  parameter int NUM_MEAS    = 2,
  parameter int TIMEOUT_CYC = 5000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rxd,
  output logic             txd,
  output logic [DIV_W-1:0] divisor,
  output logic             locked,
  output logic             error
);

  abCtrl_t    ctrl;
  logic       measFirst;
  logic       fallEdge;
  logic       riseEdge;
  logic       rxLevel;
  logic       lowSat;
  logic       measBad;
  logic       timerDone;
  logic       timeoutHit;
  logic [7:0] rxByte;

  autobaud_datapath #(
    .CNT_W      (CNT_W),
    .DIV_W      (DIV_W),
    .MIN_DIV    (MIN_DIV),
    .MAX_DIV    (MAX_DIV),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) dpInst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxd       (rxd),
    .ctrl      (ctrl),
    .measFirst (measFirst),
    .fallEdge  (fallEdge),
    .riseEdge  (riseEdge),
    .rxLevel   (rxLevel),
    .lowSat    (lowSat),
    .measBad   (measBad),
    .timerDone (timerDone),
    .timeoutHit(timeoutHit),
    .rxByte    (rxByte),
    .divisor   (divisor),
    .txd       (txd)
  );

  autobaud_control #(
    .NUM_MEAS(NUM_MEAS)
  ) ctlInst (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .fallEdge  (fallEdge),
    .riseEdge  (riseEdge),
    .rxLevel   (rxLevel),
    .lowSat    (lowSat),
    .measBad   (measBad),
    .timerDone (timerDone),
    .timeoutHit(timeoutHit),
    .rxByte    (rxByte),
    .ctrl      (ctrl),
    .measFirst (measFirst),
    .locked    (locked),
    .error     (error)
  );

endmodule

// File: rtl/autobaud_sync_chk.sv
module autobaud_sync_chk #(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 2000,
  parameter int MAX_DIV = 12000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txd,
  input logic [DIV_W-1:0] divisor,
  input logic             locked,
  input logic             error
);

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && error));

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  // R9
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(divisor));

  // R5
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked || error) |-> txd);

  // R4
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (32'(divisor) >= 32'(MIN_DIV) && 32'(divisor) <= 32'(MAX_DIV)));

endmodule

bind autobaud_sync autobaud_sync_chk #(
  .DIV_W  (DIV_W),
  .MIN_DIV(MIN_DIV),
  .MAX_DIV(MAX_DIV)
) chkInst (
  .clk    (clk),
  .rst_n  (rst_n),
  .txd    (txd),
  .divisor(divisor),
  .locked (locked),
  .error  (error)
);

// File: tb/autobaud_sync_test.sv
module autobaud_sync_test;

  localparam int CNT_W = 12;
  localparam int DIV_W = 8;
  localparam int MIN_D = 10;
  localparam int MAX_D = 40;
  localparam int NMEAS = 2;
  localparam int TOUT  = 3000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             rxd = 1'b1;
  logic             txd;
  logic [DIV_W-1:0] divisor;
  logic             locked;
  logic             error;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  done    = 1'b0;
  bit  prevLocked = 1'b0;
  bit  prevError  = 1'b0;

  always #2.5 clk = ~clk;

  autobaud_sync #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .MIN_DIV(MIN_D), .MAX_DIV(MAX_D),
    .NUM_MEAS(NMEAS), .TIMEOUT_CYC(TOUT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rxd(rxd),
    .txd(txd), .divisor(divisor), .locked(locked), .error(error)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock reference of the flag behaviour: once set, a flag never clears,
  // and the two are never set together (R9)
  always @(negedge clk) begin
    if (!rst_n) begin
      prevLocked <= 1'b0;
      prevError  <= 1'b0;
    end else begin
      if (prevLocked) check("R9 locked held", int'(locked), 1);
      if (prevError)  check("R9 error held", int'(error), 1);
      check("R9 exclusive", int'(locked && error), 0);
      prevLocked <= locked;
      prevError  <= error;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rxd = 1'b1; start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic host_low(input int lowLen, input int highLen);
    rxd = 1'b0;
    repeat (lowLen) @(negedge clk);
    rxd = 1'b1;
    repeat (highLen) @(negedge clk);
  endtask

  task automatic host_byte(input logic [7:0] data, input int bitLen, input logic stopv);
    rxd = 1'b0;
    repeat (bitLen) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = data[i];
      repeat (bitLen) @(negedge clk);
    end
    rxd = stopv;
    repeat (bitLen) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bitLen) @(negedge clk);
  endtask

  // Waits for the acknowledgement start bit and compares txd on every clock
  // against the expected 0x00 frame (R5)
  task automatic expect_ack(input int bitLen);
    int w = 0;
    while (txd !== 1'b0 && w < 100) begin
      @(negedge clk); w++;
    end
    check("R5 ack start seen", int'(txd), 0);
    for (int k = 0; k < 10 * bitLen; k++) begin
      check("R5 ack frame bit", int'(txd), (k >= 9 * bitLen) ? 1 : 0);
      @(negedge clk);
    end
    check("R5 idle after ack", int'(txd), 1);
  endtask

  // Confirms txd stays idle for a window
  task automatic expect_quiet(input int n, input string req);
    int lowSeen = 0;
    for (int k = 0; k < n; k++) begin
      if (txd !== 1'b1) lowSeen++;
      @(negedge clk);
    end
    check(req, lowSeen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 txd", int'(txd), 1);
    check("R1 locked", int'(locked), 0);
    check("R1 error", int'(error), 0);
    check("R1 divisor", int'(divisor), 0);

    // R1 traffic before start is ignored
    host_low(180, 40);
    host_low(180, 40);
    check("R1 no divisor before start", int'(divisor), 0);
    check("R1 no error before start", int'(error), 0);
    expect_quiet(100, "R1 no ack before start");

    // R2 R5 R6 nominal handshake at 20 clocks per bit
    pulse_start();
    host_low(180, 40);
    host_low(180, 0);
    expect_ack(20);
    check("R2 divisor exact", int'(divisor), 20);
    host_byte(8'h55, 20, 1'b1);
    check("R6 locked", int'(locked), 1);
    check("R6 no error", int'(error), 0);
    // R9 later traffic ignored
    host_byte(8'h00, 20, 1'b1);
    host_byte(8'h13, 20, 1'b0);
    check("R9 still locked", int'(locked), 1);
    check("R9 divisor held", int'(divisor), 20);
    check("R9 txd idle", int'(txd), 1);

    // R2 rounding down: 157 / 9 = 17.44
    do_reset(); pulse_start();
    host_low(157, 40);
    host_low(157, 0);
    expect_ack(17);
    check("R2 round down", int'(divisor), 17);
    host_byte(8'h55, 17, 1'b1);
    check("R6 locked at 17", int'(locked), 1);

    // R2 rounding up: 158 / 9 = 17.56
    do_reset(); pulse_start();
    host_low(158, 40);
    host_low(158, 0);
    expect_ack(18);
    check("R2 round up", int'(divisor), 18);

    // R3 second run one count off is accepted, first reported
    do_reset(); pulse_start();
    host_low(180, 40);
    host_low(189, 0);
    expect_ack(20);
    check("R3 first candidate kept", int'(divisor), 20);
    check("R3 no error", int'(error), 0);

    // R3 second run three counts off fails
    do_reset(); pulse_start();
    host_low(180, 40);
    host_low(207, 0);
    repeat (6) @(negedge clk);
    check("R3 mismatch error", int'(error), 1);
    expect_quiet(300, "R3 no ack on mismatch");

    // R4 below range
    do_reset(); pulse_start();
    host_low(72, 10);
    check("R4 below range error", int'(error), 1);
    expect_quiet(200, "R4 no ack below range");

    // R4 above range
    do_reset(); pulse_start();
    host_low(405, 10);
    check("R4 above range error", int'(error), 1);

    // R4 lower bound accepted
    do_reset(); pulse_start();
    host_low(90, 20);
    host_low(90, 0);
    expect_ack(10);
    check("R4 lower bound divisor", int'(divisor), 10);

    // R4 upper bound accepted
    do_reset(); pulse_start();
    host_low(360, 80);
    host_low(360, 0);
    expect_ack(40);
    check("R4 upper bound divisor", int'(divisor), 40);

    // R7 wrong confirmation byte
    do_reset(); pulse_start();
    host_low(180, 40);
    host_low(180, 0);
    expect_ack(20);
    host_byte(8'h54, 20, 1'b1);
    check("R7 wrong byte error", int'(error), 1);
    check("R7 wrong byte not locked", int'(locked), 0);

    // R7 framing error on the confirmation
    do_reset(); pulse_start();
    host_low(180, 40);
    host_low(180, 0);
    expect_ack(20);
    host_byte(8'h55, 20, 1'b0);
    check("R7 framing error", int'(error), 1);
    check("R7 framing not locked", int'(locked), 0);

    // R8 confirmation timeout
    do_reset(); pulse_start();
    host_low(180, 40);
    host_low(180, 0);
    expect_ack(20);
    repeat (TOUT - 100) @(negedge clk);
    check("R8 no error before timeout", int'(error), 0);
    repeat (200) @(negedge clk);
    check("R8 timeout error", int'(error), 1);

    // R10 line stuck low saturates the counter
    do_reset(); pulse_start();
    rxd = 1'b0;
    repeat ((1 << CNT_W) - 100) @(negedge clk);
    check("R10 no error before full scale", int'(error), 0);
    repeat (200) @(negedge clk);
    check("R10 stuck low error", int'(error), 1);
    rxd = 1'b1;
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule